// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Correction

This block sits behind the analog pipeline of a multi-stage converter. Every clock, each of the five stages hands over a small raw code, and each stage is one cycle behind the stage before it. The block delays each code so that the five codes from one input sample arrive together. It then adds them with weights that overlap by one bit, removes the fixed bias that the redundancy adds, and produces a 14-bit word.

A corrected value above full scale drives the word to all ones. A value below zero drives it to all zeros. In both cases the out-of-range flag is raised. Data, flag and valid leave the block from one register stage.

After reset the output stays invalid until the alignment delay lines have filled. An external busy input mutes the output while it is high. The delay lines keep moving during busy, so no sample is held back.

Top module: `adc_pipe_align`

## Requirements
- R1: The code of stage k (k = 1..5, stage 1 first in the pipeline) is delayed by 5-k cycles. The result for a sample appears after the clock edge at which its stage 5 code is presented. Its stage 1 code is presented four cycles earlier.
- R2: The raw sum is stage5 + 4·stage4 + 32·stage3 + 256·stage2 + 2048·stage1. This gives shifts of 0, 2, 5, 8 and 11. Stages 1 to 4 are 4-bit fields in `lead_codes_i`: stage k occupies bits [4(k-1)+3 : 4(k-1)]. Stage 5 is the 2-bit `last_code_i`.
- R3: The output word is the raw sum minus a redundancy bias of 9360, which equals 4·(2048+256+32+4). A raw sum of exactly 9360 gives data 0 with the flag low.
- R4: A corrected value above 16383 gives data 16383 (all ones) with the flag high. A corrected value of exactly 16383 is in range.
- R5: A raw sum below 9360 gives data 0 (all zeros) with the flag high.
- R6: The flag is registered in the same cycle as the data it belongs to. It is low for every in-range result.
- R7: After reset is released, valid stays low for the first four clock edges. From the fifth edge on, valid is high for every edge at which busy is low.
- R8: If busy is high at a capture edge, the following cycle shows valid 0, data 0 and flag 0. The delay lines still advance. Samples whose capture edge falls outside the busy window come out unchanged.
- R9: While reset is low, valid, flag and data are all 0.
- R10: The overlap carries correctly: a stage code with its top bit set adds into the bit field of the stage before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Output mute, sampled at each edge |
| lead_codes_i | input | 16 | Raw codes of stages 1 to 4, 4 bits each, stage 1 in the low bits |
| last_code_i | input | 2 | Raw code of stage 5 |
| data_o | output | 14 | Corrected and clamped result, bit 0 is the LSB |
| oor_o | output | 1 | Out-of-range flag for data_o |
| valid_o | output | 1 | data_o holds a result |

## Verification
The assertions assume that busy_i and the stage codes are synchronous to clk and stable around the rising edge. They also assume that reset is the only way the fill state is cleared. The stimulus changes every input only at the falling edge. It drives each stage with the skew the pipeline implies, and it uses any value that fits each code width. The busy input is raised for a single contiguous window well after the fill period, so the fill and mute behaviours are observed separately.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

    typedef enum logic [1:0] {
        RANGE_OK    = 2'd0,
        RANGE_OVER  = 2'd1,
        RANGE_UNDER = 2'd2
    } range_e;

    // Left shift applied to lead stage idx (0 = first stage)
    function automatic int lead_shift(input int idx, input int lead_n,
                                      input int eff, input int last_w);
        return eff * (lead_n - 1 - idx) + last_w;
    endfunction

    // Fixed offset added by the redundant codes of all lead stages
    function automatic int redundancy_bias(input int lead_n, input int eff,
                                           input int last_w, input int offset);
        int acc;
        acc = 0;
        for (int i = 0; i < lead_n; i++)
            acc += offset * (1 << lead_shift(i, lead_n, eff, last_w));
        return acc;
    endfunction

endpackage

// File: rtl/stage_delay.sv
module stage_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = din;
        for (int i = 1; i < DEPTH; i++)
            pipe_d[i] = pipe_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[DEPTH-1];

    AST_DELAY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q[0] == $past(din) || $past(!rst_n)) else $error("delay head"); // R1
endmodule

// File: rtl/code_combiner.sv
module code_combiner #(
    parameter int LEAD_N = 4,
    parameter int RAW_W  = 4,
    parameter int LAST_W = 2,
    parameter int OFFSET = 4,
    localparam int EFF   = RAW_W - 1,
    localparam int OUT_W = EFF * LEAD_N + LAST_W
) (
    input  logic [LEAD_N*RAW_W-1:0]  lead_codes,
    input  logic [LAST_W-1:0]        last_code,
    output logic [OUT_W-1:0]         data,
    output adc_align_pkg::range_e    range
);
    import adc_align_pkg::*;

    localparam int SUM_W = RAW_W + EFF * (LEAD_N - 1) + LAST_W + 1;
    localparam logic [SUM_W-1:0] BIAS =
        SUM_W'(redundancy_bias(LEAD_N, EFF, LAST_W, OFFSET));
    localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << OUT_W) - 1);

    logic [SUM_W-1:0] sum_raw;
    logic [SUM_W-1:0] corr;

    always_comb begin
        sum_raw = SUM_W'(last_code);
        for (int i = 0; i < LEAD_N; i++)
            sum_raw = sum_raw + (SUM_W'(lead_codes[i*RAW_W +: RAW_W])
                                 << lead_shift(i, LEAD_N, EFF, LAST_W));
        corr = sum_raw - BIAS;
        if (sum_raw < BIAS) begin
            range = RANGE_UNDER;
            data  = '0;
        end else if (corr > FULL) begin
            range = RANGE_OVER;
            data  = '1;
        end else begin
            range = RANGE_OK;
            data  = corr[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/adc_pipe_align.sv
module adc_pipe_align #(
    parameter int LEAD_N = 4,
    parameter int RAW_W  = 4,
    parameter int LAST_W = 2,
    parameter int OFFSET = 4,
    localparam int OUT_W = (RAW_W - 1) * LEAD_N + LAST_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy_i,
    input  logic [LEAD_N*RAW_W-1:0] lead_codes_i,
    input  logic [LAST_W-1:0]       last_code_i,
    output logic [OUT_W-1:0]        data_o,
    output logic                    oor_o,
    output logic                    valid_o
);
    import adc_align_pkg::*;

    localparam int FILL_W = $clog2(LEAD_N + 1);

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic              valid;
        logic              oor;
        logic [OUT_W-1:0]  data;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [LEAD_N*RAW_W-1:0] aligned_lead;
    logic [OUT_W-1:0]        comb_data;
    range_e                  comb_range;

    // Stage g+1 waits LEAD_N-g cycles for the last stage to catch up
    for (genvar g = 0; g < LEAD_N; g++) begin : g_skew
        stage_delay #(.W(RAW_W), .DEPTH(LEAD_N - g)) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (lead_codes_i[g*RAW_W +: RAW_W]),
            .dout (aligned_lead[g*RAW_W +: RAW_W])
        );
    end

    code_combiner #(
        .LEAD_N(LEAD_N), .RAW_W(RAW_W), .LAST_W(LAST_W), .OFFSET(OFFSET)
    ) u_comb (
        .lead_codes(aligned_lead),
        .last_code (last_code_i),
        .data      (comb_data),
        .range     (comb_range)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.fill != FILL_W'(LEAD_N))
            st_d.fill = st_q.fill + 1'b1;
        if (st_q.fill == FILL_W'(LEAD_N) && !busy_i) begin
            st_d.valid = 1'b1;
            st_d.oor   = (comb_range != RANGE_OK);
            st_d.data  = comb_data;
        end else begin
            st_d.valid = 1'b0;
            st_d.oor   = 1'b0;
            st_d.data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign oor_o   = st_q.oor;
    assign valid_o = st_q.valid;

    // Edge count since reset, kept only for the fill check
    logic [FILL_W:0] chk_edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                chk_edges_q <= '0;
        else if (chk_edges_q <= (FILL_W+1)'(LEAD_N)) chk_edges_q <= chk_edges_q + 1'b1;
    end

    AST_OOR_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> (data_o == '0 || data_o == '1)) else $error("clamp"); // R4
    AST_BUSY_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!valid_o && !oor_o && data_o == '0)) else $error("busy"); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!oor_o && data_o == '0)) else $error("idle"); // R6
    AST_FILL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> chk_edges_q > (FILL_W+1)'(LEAD_N)) else $error("fill"); // R7
    AST_STAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !busy_i) |=> valid_o) else $error("drop"); // R7
endmodule

// File: tb/adc_pipe_align_bench.sv
`timescale 1ns/1ps
module adc_pipe_align_bench;
    localparam int LEAD_N = 4;
    localparam int RAW_W  = 4;
    localparam int LAST_W = 2;
    localparam int OUT_W  = 14;
    localparam int NSWEEP = 1024;
    localparam int N      = NSWEEP + 4;
    localparam int CYC    = N + LEAD_N;
    localparam int BIAS   = 9360;
    localparam int FULL   = 16383;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                    rst_n;
    logic                    busy_i;
    logic [LEAD_N*RAW_W-1:0] lead_codes_i;
    logic [LAST_W-1:0]       last_code_i;
    logic [OUT_W-1:0]        data_o;
    logic                    oor_o;
    logic                    valid_o;

    adc_pipe_align u_adc_pipe_align (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
        .lead_codes_i(lead_codes_i), .last_code_i(last_code_i),
        .data_o(data_o), .oor_o(oor_o), .valid_o(valid_o)
    );

    int cs [N][5];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int s, input int k);
        if (s < 0 || s >= N) return 0;
        return cs[s][k];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Sweep stage1 x stage2 x stage5 fully, stages 3/4 patterned
        for (int i = 0; i < NSWEEP; i++) begin
            cs[i][0] = (i >> 6) & 15;
            cs[i][1] = (i >> 2) & 15;
            cs[i][2] = (i * 7) % 16;
            cs[i][3] = (i * 5 + 3) % 16;
            cs[i][4] = i & 3;
        end
        // Boundary samples: bias-1, bias, full, full+1 (R3 R4 R5)
        cs[NSWEEP+0] = '{4, 4, 4, 3, 3};
        cs[NSWEEP+1] = '{4, 4, 4, 4, 0};
        cs[NSWEEP+2] = '{12, 4, 4, 3, 3};
        cs[NSWEEP+3] = '{12, 4, 4, 4, 0};

        rst_n = 1'b0; busy_i = 1'b0; lead_codes_i = '0; last_code_i = '0;
        repeat (2) @(negedge clk);
        check("R9 reset valid", int'(valid_o), 0);
        check("R9 reset flag",  int'(oor_o),   0);
        check("R9 reset data",  int'(data_o),  0);

        rst_n = 1'b1;
        for (int c = 0; c < CYC; c++) begin
            bit busy_now;
            busy_now = (c >= 300 && c < 310);
            busy_i = busy_now;
            for (int k = 0; k < LEAD_N; k++)
                lead_codes_i[k*RAW_W +: RAW_W] = RAW_W'(code_of(c - k, k));
            last_code_i = LAST_W'(code_of(c - LEAD_N, LEAD_N));
            @(posedge clk);
            #1;
            if (c < LEAD_N) begin
                check("R7 fill valid", int'(valid_o), 0);
                check("R7 fill data",  int'(data_o),  0);
            end else if (busy_now) begin
                check("R8 busy valid", int'(valid_o), 0);
                check("R8 busy flag",  int'(oor_o),   0);
                check("R8 busy data",  int'(data_o),  0);
            end else begin
                int s, raw, corr, exp_d, exp_f;
                s   = c - LEAD_N;
                raw = cs[s][4] + 4*cs[s][3] + 32*cs[s][2] + 256*cs[s][1] + 2048*cs[s][0];
                corr = raw - BIAS;
                if (raw < BIAS)      begin exp_d = 0;    exp_f = 1; end
                else if (corr > FULL) begin exp_d = FULL; exp_f = 1; end
                else                 begin exp_d = corr; exp_f = 0; end
                check("R7 R8 valid", int'(valid_o), 1);
                check("R6 flag",     int'(oor_o),   exp_f);
                if (raw < BIAS)        check("R5 under data", int'(data_o), exp_d);
                else if (corr > FULL)  check("R4 over data",  int'(data_o), exp_d);
                else                   check("R1 R2 R3 R10 data", int'(data_o), exp_d);
            end
            @(negedge clk);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule